// File: doc/BRIEF.md
# Program/Erase Busy Status Reporter

This block sits on the read side of a byte-wide flash device while a write operation is running inside the array. The command decoder gives it a one-cycle start pulse, a two-bit operation code and the most significant bit of the byte being programmed. The block then holds a busy flag for a fixed number of clock cycles. The count is one parameter for a byte program, which stands in for tens of microseconds. A second parameter covers a chip erase or a boot-lock set, which stands in for about a second.

While the block is busy, a host read does not return array data. It returns a status byte, and the host can watch for completion in either of two ways. The polling bit is the most significant bit: it reads as the inverse of the programmed bit during a program, and as zero during an erase or lock. The toggle bit is the bit below it, and it inverts on every new read access. Once the count expires, the block returns to plain array reads with no further command.

The block also gates the data bus from the active-low chip enable and output enable. The bus is driven only when both are low, and the driven data is registered one cycle behind the enables.

Top module: `pe_busy_status`

## Requirements
- R1: After a synchronous reset, `busy_o`, `dq_oe_o` and `dq_o` are all zero. A reset during a busy period ends that period.
- R2: A start with op code 2'b00 (byte program) raises `busy_o` on the cycle after the start. `busy_o` then stays high for exactly PROG_CYCLES cycles.
- R3: A start with op code 2'b01 (chip erase) or 2'b10 (lock set) raises `busy_o` on the cycle after the start. `busy_o` then stays high for exactly ERASE_CYCLES cycles.
- R4: A start with op code 2'b11 has no effect. `busy_o` stays low and reads keep returning array data.
- R5: A start that arrives while `busy_o` is high is ignored. The running operation keeps its length and its polling polarity.
- R6: `dq_oe_o` is high one cycle after `ce_n_i` and `oe_n_i` are both low, and low one cycle after either one is high. `dq_o` is zero whenever `dq_oe_o` is low.
- R7: During a byte program, bit DW-1 of a read returns the inverse of `prog_msb_i` as it was captured at the start.
- R8: During an erase or a lock set, bit DW-1 of a read returns 0.
- R9: During a busy period, bit DW-2 flips on each new read access. A new access is the cycle in which the enables first become both low. The first access after a start reads 1. Holding the enables low does not flip the bit again. Bits DW-3..0 read 0.
- R10: Once `busy_o` has fallen, a read returns `arr_data_i` one cycle later. Bit DW-2 then stays steady across repeated accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle start pulse from the command decoder |
| op_i | input | 2 | Operation code: 00 program, 01 erase, 10 lock set, 11 none |
| prog_msb_i | input | 1 | Most significant bit of the byte being programmed |
| arr_data_i | input | DW | Array read data for normal reads |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dq_o | output | DW | Registered read data |
| dq_oe_o | output | 1 | Registered bus drive enable |
| busy_o | output | 1 | Operation in progress |

## Verification
`busy_o` rises one clock after the start is sampled and stays high for a known number of cycles. The bench counts its high cycles itself, at falling edges, and compares the total with the parameter. Read data and the drive enable are due one clock after the enables change. Each read check therefore drives the enables at one falling edge and samples at the next, away from the rising edge that captures them. No read is placed on the cycle where busy ends, so every expected value depends on only one state of the busy flag.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_ERASE = 2'b01,
    OP_LOCK  = 2'b10,
    OP_NONE  = 2'b11
  } pe_op_e;
endpackage

// File: rtl/pes_timer.sv
module pes_timer #(
  parameter int PROG_CYCLES  = 50,
  parameter int ERASE_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  pes_pkg::pe_op_e  op_i,
  output logic             busy_o,
  output logic             accept_o
);
  import pes_pkg::*;

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign accept_o = start_i && !busy_q && (op_i != OP_NONE);
  assign load_val = (op_i == OP_PROG) ? CW'(PROG_CYCLES - 1) : CW'(ERASE_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pes_rdgate.sv
module pes_rdgate (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_i,
  input  logic oe_n_i,
  output logic rd_en_o,
  output logic acc_o
);
  logic rd_q;

  assign rd_en_o = !ce_n_i && !oe_n_i;
  assign acc_o   = rd_en_o && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_en_o;
  end
endmodule

// File: rtl/pes_stat.sv
module pes_stat #(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  pes_pkg::pe_op_e  op_i,
  input  logic             prog_msb_i,
  input  logic             busy_i,
  input  logic             rd_en_i,
  input  logic             acc_i,
  input  logic [DW-1:0]    arr_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  import pes_pkg::*;

  localparam int POLL_BIT = DW - 1;
  localparam int TGL_BIT  = DW - 2;

  pe_op_e        op_q;
  logic          msb_q;
  logic          tgl_q;
  logic          tgl_nxt;
  logic [DW-1:0] stat_byte;
  logic [DW-1:0] dq_q;
  logic          oe_q;

  assign tgl_nxt = tgl_q ^ (acc_i && busy_i);

  always_comb begin
    stat_byte           = '0;
    stat_byte[POLL_BIT] = (op_q == OP_PROG) ? ~msb_q : 1'b0;
    stat_byte[TGL_BIT]  = tgl_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_NONE;
      msb_q <= 1'b0;
      tgl_q <= 1'b0;
      dq_q  <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (accept_i) begin
        op_q  <= op_i;
        msb_q <= prog_msb_i;
        tgl_q <= 1'b0;
      end else begin
        tgl_q <= tgl_nxt;
      end
      oe_q <= rd_en_i;
      if (!rd_en_i)    dq_q <= '0;
      else if (busy_i) dq_q <= stat_byte;
      else             dq_q <= arr_i;
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;
endmodule

// File: rtl/pe_busy_status.sv
module pe_busy_status #(
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 50,
  parameter int ERASE_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          prog_msb_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          busy_o
);
  import pes_pkg::*;

  pe_op_e op_e;
  logic   accept;
  logic   busy;
  logic   rd_en;
  logic   acc;

  assign op_e = pe_op_e'(op_i);

  pes_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_e),
    .busy_o(busy), .accept_o(accept)
  );

  pes_rdgate u_gate (
    .clk(clk), .rst(rst), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .rd_en_o(rd_en), .acc_o(acc)
  );

  pes_stat #(.DW(DW)) u_stat (
    .clk(clk), .rst(rst), .accept_i(accept), .op_i(op_e),
    .prog_msb_i(prog_msb_i), .busy_i(busy), .rd_en_i(rd_en), .acc_i(acc),
    .arr_i(arr_data_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/pes_chk.sv
module pes_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic          ce_n_i,
  input logic          oe_n_i,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o,
  input logic          busy_o
);
  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (rst)
    (!ce_n_i && !oe_n_i) |=> dq_oe_o); // R6
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    (ce_n_i || oe_n_i) |=> !dq_oe_o); // R6
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    !dq_oe_o |-> (dq_o == '0)); // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R2
  AST_NO_OP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start_i && (op_i == 2'b11) && !busy_o) |=> !busy_o); // R4
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && dq_oe_o) |-> (dq_o[DW-3:0] == '0)); // R9
endmodule

bind pe_busy_status pes_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
  .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .dq_o(dq_o),
  .dq_oe_o(dq_oe_o), .busy_o(busy_o)
);

// File: tb/sim_pe_busy_status.sv
module sim_pe_busy_status;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int PROGN = 20;
  localparam int ERASEN = 60;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic          prog_msb_i = 1'b0;
  logic [DW-1:0] arr_data_i = '0;
  logic          ce_n_i = 1'b1;
  logic          oe_n_i = 1'b1;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;
  logic          busy_o;

  int nchk = 0;
  int nfail = 0;
  int bcnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_busy_status #(.DW(DW), .PROG_CYCLES(PROGN), .ERASE_CYCLES(ERASEN)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .prog_msb_i(prog_msb_i),
    .arr_data_i(arr_data_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .busy_o(busy_o)
  );

  // {op, programmed byte, array byte}
  localparam logic [17:0] VEC [4] = '{
    {2'b00, 8'hA5, 8'h3C},
    {2'b00, 8'h12, 8'hC3},
    {2'b01, 8'h77, 8'h5A},
    {2'b10, 8'hFF, 8'h81}
  };

  task automatic step();
    @(negedge clk);
    if (busy_o) bcnt++;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy_o; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1: reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 oe", dq_oe_o, 0);
    chk("R1 dq", dq_o, 0);
    rst = 1'b0;
    step();

    foreach (VEC[k]) begin
      logic [1:0] op;
      logic [7:0] wd;
      logic [7:0] ad;
      logic e7;
      int n;
      op = VEC[k][17:16]; wd = VEC[k][15:8]; ad = VEC[k][7:0];
      e7 = (op == 2'b00) ? ~wd[7] : 1'b0;
      n  = (op == 2'b00) ? PROGN : ERASEN;
      arr_data_i = ad;
      bcnt = 0;
      op_i = op; prog_msb_i = wd[7]; start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk((op == 2'b00) ? "R2 busy rise" : "R3 busy rise", busy_o, 1);
      step();
      ce_n_i = 1'b0; oe_n_i = 1'b0;
      step();
      chk("R6 oe on", dq_oe_o, 1);
      chk((op == 2'b00) ? "R7 R9 first read" : "R8 R9 first read", dq_o, {e7, 1'b1, 6'b0});
      oe_n_i = 1'b1;
      step();
      chk("R6 oe off", dq_oe_o, 0);
      chk("R6 dq zero", dq_o, 0);
      oe_n_i = 1'b0;
      step();
      chk("R9 second read", dq_o, {e7, 1'b0, 6'b0});
      step();
      chk("R9 held no toggle", dq_o, {e7, 1'b0, 6'b0});
      oe_n_i = 1'b1;
      wait_idle();
      chk((op == 2'b00) ? "R2 busy length" : "R3 busy length", bcnt, n);
      oe_n_i = 1'b0;
      step();
      chk("R10 array read", dq_o, ad);
      oe_n_i = 1'b1;
      step();
      oe_n_i = 1'b0;
      step();
      chk("R10 no toggle after", dq_o, ad);
      ce_n_i = 1'b1; oe_n_i = 1'b1;
      step();
    end

    // R4: op code 11 ignored; R6 with only oe low
    arr_data_i = 8'h6E;
    op_i = 2'b11; start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk("R4 no busy", busy_o, 0);
    oe_n_i = 1'b0;
    step();
    chk("R6 ce high no drive", dq_oe_o, 0);
    ce_n_i = 1'b0;
    step();
    chk("R4 array read", dq_o, 8'h6E);
    ce_n_i = 1'b1; oe_n_i = 1'b1;
    step();

    // R5: start while busy is ignored
    bcnt = 0;
    op_i = 2'b00; prog_msb_i = 1'b0; start_i = 1'b1;
    step();
    start_i = 1'b0;
    repeat (3) step();
    op_i = 2'b01; prog_msb_i = 1'b1; start_i = 1'b1;
    step();
    start_i = 1'b0;
    ce_n_i = 1'b0; oe_n_i = 1'b0;
    step();
    chk("R5 polarity kept", dq_o, 8'hC0);
    ce_n_i = 1'b1; oe_n_i = 1'b1;
    wait_idle();
    chk("R5 length kept", bcnt, PROGN);

    // R1: reset during busy
    op_i = 2'b01; start_i = 1'b1;
    step();
    start_i = 1'b0;
    repeat (4) step();
    rst = 1'b1;
    step();
    chk("R1 reset ends busy", busy_o, 0);
    rst = 1'b0;
    step();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule